// File: doc/BRIEF.md
# Shared-RAM Dual Stack Unit

This block is the stack datapath of a small nibble-oriented stack-machine core. A single 256-cell by 4-bit RAM holds two stacks. The data stack is 4 bits wide. Its top element is cached in a register that the ALU uses as an accumulator, and the element below it (TOS-1) is read straight from RAM at the data stack pointer. The return stack keeps 12-bit entries such as return addresses and loop indices. Each entry is split into three nibbles in consecutive cells.

The core drives one command per cycle. The data stack has push, pop and swap of the top two elements. The return stack has push, pop, and an exchange that trades the cached data top with the top return cell. Each stack's floor and ceiling come from configuration inputs. A command that would cross one of them is dropped, and a one-cycle error pulse is raised for it.

Return-stack transfers take three cycles, one nibble per cycle, because the RAM takes only one write per cycle. While such a transfer runs, `busy` is high and new commands are ignored.

Top module: `dual_stack_unit`

## Requirements
- R1: In the cycle after a synchronous reset (`rst_n` low at a clock edge), the following hold: `tos` is 0, `sp` equals `es_base`, `rp` equals `rs_base`, `rs_dout` is 0, and `busy` and all four error flags are 0.
- R2: An accepted data push writes the old `tos` to RAM[`sp`+1], increments `sp`, and loads `es_din` into `tos`, all at one clock edge.
- R3: An accepted data pop loads `tos` from RAM[`sp`] and decrements `sp` at one edge. `nos` always shows RAM[`sp`].
- R4: An accepted swap exchanges `tos` with RAM[`sp`] and leaves `sp` unchanged.
- R5: A data push with `sp` equal to `es_limit` changes nothing and pulses `es_ovf` for one cycle. A pop or swap with `sp` equal to `es_base` changes nothing and pulses `es_unf`.
- R6: An accepted return push stores `rs_din` into three cells. Bits [11:8] go to RAM[`rp`+1], bits [7:4] to RAM[`rp`+2] and bits [3:0] to RAM[`rp`+3]. `rp` ends 3 higher, and `busy` is high for exactly the two cycles after the accepting edge.
- R7: An accepted return pop reads RAM[`rp`], RAM[`rp`-1] and RAM[`rp`-2] as bits [3:0], [7:4] and [11:8]. It presents the 12-bit entry on `rs_dout` once `busy` falls, with `rp` 3 lower.
- R8: While `busy` is high, every command is ignored, and `sp` and `tos` hold.
- R9: When several commands are asserted together, only one executes. The order is data push, data pop, swap, return push, return pop, exchange, so at most one error flag is raised per cycle.
- R10: An accepted exchange swaps `tos` with RAM[`rp`], the least significant nibble of the top return entry, in one cycle.
- R11: A return push with fewer than 3 cells between `rp` and `rs_limit` pulses `rs_ovf`. A return pop or exchange with fewer than 3 cells between `rs_base` and `rp` pulses `rs_unf`. In both cases `rp`, `tos` and `rs_dout` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| es_base | input | 8 | Data stack floor address |
| es_limit | input | 8 | Data stack ceiling address |
| rs_base | input | 8 | Return stack floor address |
| rs_limit | input | 8 | Return stack ceiling address |
| es_push | input | 1 | Push `es_din` on the data stack |
| es_pop | input | 1 | Pop the data stack |
| es_swap | input | 1 | Swap TOS and TOS-1 |
| es_din | input | 4 | Value to push |
| rs_push | input | 1 | Push `rs_din` on the return stack |
| rs_pop | input | 1 | Pop the return stack into `rs_dout` |
| rs_xchg | input | 1 | Exchange TOS with the top return nibble |
| rs_din | input | 12 | Return entry to push |
| tos | output | 4 | Cached top of the data stack |
| nos | output | 4 | TOS-1, read from RAM[`sp`] |
| sp | output | 8 | Data stack pointer |
| rp | output | 8 | Return stack pointer |
| rs_dout | output | 12 | Last popped return entry |
| busy | output | 1 | Multi-nibble transfer in progress |
| es_ovf | output | 1 | Data stack overflow pulse |
| es_unf | output | 1 | Data stack underflow pulse |
| rs_ovf | output | 1 | Return stack overflow pulse |
| rs_unf | output | 1 | Return stack underflow pulse |

## Verification
The assertions check on every cycle the following single-edge rules:
- a data push or pop moves `sp` by one and updates `tos` from `es_din` or `nos`;
- a data push at the ceiling is dropped and flagged;
- `busy` freezes the data stack;
- an accepted return push keeps `busy` high for exactly two cycles;
- no two error flags are raised together.

Some behaviour spans several cycles and only the bench's scenarios can show it. This covers the nibble order of return entries through push, exchange and pop, and the reconstruction of a 12-bit entry after an exchange has altered it. It also covers the priority among simultaneous commands, and filling and draining both stacks to their programmed bounds.

// File: rtl/dual_stack_unit.sv
module dual_stack_unit #(
  parameter int AW = 8,
  parameter int NW = 4,
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] es_base,
  input  logic [AW-1:0] es_limit,
  input  logic [AW-1:0] rs_base,
  input  logic [AW-1:0] rs_limit,
  input  logic          es_push,
  input  logic          es_pop,
  input  logic          es_swap,
  input  logic [NW-1:0] es_din,
  input  logic          rs_push,
  input  logic          rs_pop,
  input  logic          rs_xchg,
  input  logic [RW-1:0] rs_din,
  output logic [NW-1:0] tos,
  output logic [NW-1:0] nos,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] rp,
  output logic [RW-1:0] rs_dout,
  output logic          busy,
  output logic          es_ovf,
  output logic          es_unf,
  output logic          rs_ovf,
  output logic          rs_unf
);
  localparam int NPR   = RW / NW;
  localparam int CW    = $clog2(NPR + 1);
  localparam int DEPTH = 1 << AW;

  logic [NW-1:0]    mem [DEPTH];
  logic [CW-1:0]    left_q;
  logic             wr_dir_q;
  logic [RW-NW-1:0] wbuf_q;
  logic [NW-1:0]    rcell;

  assign busy  = left_q != '0;
  assign nos   = mem[sp];
  assign rcell = mem[rp];

  logic es_room, es_has, rs_room, rs_has;
  assign es_room = sp != es_limit;
  assign es_has  = sp != es_base;
  assign rs_room = (rs_limit - rp) >= AW'(NPR);
  assign rs_has  = (rp - rs_base) >= AW'(NPR);

  logic go_epush, go_epop, go_eswap, rsel, go_rpush, go_rpop, go_rx;
  assign go_epush = !busy && es_push;
  assign go_epop  = !busy && !es_push && es_pop;
  assign go_eswap = !busy && !es_push && !es_pop && es_swap;
  assign rsel     = !busy && !es_push && !es_pop && !es_swap;
  assign go_rpush = rsel && rs_push;
  assign go_rpop  = rsel && !rs_push && rs_pop;
  assign go_rx    = rsel && !rs_push && !rs_pop && rs_xchg;

  logic          we;
  logic [AW-1:0] waddr;
  logic [NW-1:0] wdata;

  always_comb begin
    we    = 1'b0;
    waddr = sp;
    wdata = tos;
    if (go_epush && es_room) begin
      we    = 1'b1;
      waddr = sp + AW'(1);
    end else if (go_eswap && es_has) begin
      we    = 1'b1;
    end else if (go_rx && rs_has) begin
      we    = 1'b1;
      waddr = rp;
    end else if (go_rpush && rs_room) begin
      we    = 1'b1;
      waddr = rp + AW'(1);
      wdata = rs_din[RW-1 -: NW];
    end else if (busy && wr_dir_q) begin
      we    = 1'b1;
      waddr = rp + AW'(1);
      wdata = wbuf_q[RW-NW-1 -: NW];
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos      <= '0;
      sp       <= es_base;
      rp       <= rs_base;
      rs_dout  <= '0;
      left_q   <= '0;
      wr_dir_q <= 1'b0;
      wbuf_q   <= '0;
      es_ovf   <= 1'b0;
      es_unf   <= 1'b0;
      rs_ovf   <= 1'b0;
      rs_unf   <= 1'b0;
    end else begin
      es_ovf <= go_epush && !es_room;
      es_unf <= (go_epop || go_eswap) && !es_has;
      rs_ovf <= go_rpush && !rs_room;
      rs_unf <= (go_rpop || go_rx) && !rs_has;

      if (busy) begin
        left_q <= left_q - CW'(1);
        if (wr_dir_q) begin
          rp     <= rp + AW'(1);
          wbuf_q <= wbuf_q << NW;
        end else begin
          rp      <= rp - AW'(1);
          rs_dout <= {rcell, rs_dout[RW-1:NW]};
        end
      end else if (go_epush && es_room) begin
        sp  <= sp + AW'(1);
        tos <= es_din;
      end else if (go_epop && es_has) begin
        sp  <= sp - AW'(1);
        tos <= nos;
      end else if (go_eswap && es_has) begin
        tos <= nos;
      end else if (go_rpush && rs_room) begin
        rp       <= rp + AW'(1);
        wbuf_q   <= rs_din[RW-NW-1:0];
        wr_dir_q <= 1'b1;
        left_q   <= CW'(NPR - 1);
      end else if (go_rpop && rs_has) begin
        rp       <= rp - AW'(1);
        rs_dout  <= {rcell, rs_dout[RW-1:NW]};
        wr_dir_q <= 1'b0;
        left_q   <= CW'(NPR - 1);
      end else if (go_rx && rs_has) begin
        tos <= rcell;
      end
    end
  end
endmodule

// File: rtl/dual_stack_unit_chk.sv
module dual_stack_unit_chk #(
  parameter int AW = 8,
  parameter int NW = 4,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] es_base,
  input logic [AW-1:0] es_limit,
  input logic [AW-1:0] rs_base,
  input logic [AW-1:0] rs_limit,
  input logic          es_push,
  input logic          es_pop,
  input logic          es_swap,
  input logic [NW-1:0] es_din,
  input logic          rs_push,
  input logic          rs_pop,
  input logic          rs_xchg,
  input logic [RW-1:0] rs_din,
  input logic [NW-1:0] tos,
  input logic [NW-1:0] nos,
  input logic [AW-1:0] sp,
  input logic [AW-1:0] rp,
  input logic [RW-1:0] rs_dout,
  input logic          busy,
  input logic          es_ovf,
  input logic          es_unf,
  input logic          rs_ovf,
  input logic          rs_unf
);
  logic rpush_ok;
  assign rpush_ok = !busy && !es_push && !es_pop && !es_swap && rs_push
                    && ((rs_limit - rp) >= AW'(RW / NW));

  AST_PUSH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && es_push && sp != es_limit) |=> (tos == $past(es_din) && sp == $past(sp) + AW'(1))); // R2

  AST_POP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !es_push && es_pop && sp != es_base) |=> (tos == $past(nos) && sp == $past(sp) - AW'(1))); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && es_push && sp == es_limit) |=> (es_ovf && $stable(sp) && $stable(tos))); // R5

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(sp) && $stable(tos))); // R8

  AST_RPUSH_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rpush_ok |=> busy ##1 busy ##1 !busy); // R6

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({es_ovf, es_unf, rs_ovf, rs_unf}) <= 1); // R9
endmodule

bind dual_stack_unit dual_stack_unit_chk #(.AW(AW), .NW(NW), .RW(RW)) u_chk (.*);

// File: tb/tb_dual_stack_unit.sv
`timescale 1ns/1ps
module tb_dual_stack_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] es_base = 8'h10, es_limit = 8'h14, rs_base = 8'h80, rs_limit = 8'h86;
  logic es_push = 0, es_pop = 0, es_swap = 0, rs_push = 0, rs_pop = 0, rs_xchg = 0;
  logic [3:0] es_din = '0;
  logic [11:0] rs_din = '0;
  logic [3:0] tos, nos;
  logic [7:0] sp, rp;
  logic [11:0] rs_dout;
  logic busy, es_ovf, es_unf, rs_ovf, rs_unf;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] fl;

  always #2 clk = ~clk;

  dual_stack_unit dut (.*);

  // op: 1 data push, 2 data pop, 3 swap ; fields op, din, tos, nos, sp
  localparam int NV = 7;
  localparam logic [22:0] VEC [NV] = '{
    {3'd1, 4'h3, 4'h3, 4'h0, 8'h11},
    {3'd1, 4'h5, 4'h5, 4'h3, 8'h12},
    {3'd1, 4'h9, 4'h9, 4'h5, 8'h13},
    {3'd3, 4'h0, 4'h5, 4'h9, 8'h13},
    {3'd2, 4'h0, 4'h9, 4'h3, 8'h12},
    {3'd2, 4'h0, 4'h3, 4'h0, 8'h11},
    {3'd1, 4'hA, 4'hA, 4'h3, 8'h12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic [11:0] d);
    @(negedge clk);
    es_push = (op == 1); es_pop = (op == 2); es_swap = (op == 3);
    rs_push = (op == 4); rs_pop = (op == 5); rs_xchg = (op == 6);
    es_din = d[3:0]; rs_din = d;
    @(negedge clk);
    {es_push, es_pop, es_swap, rs_push, rs_pop, rs_xchg} = '0;
    fl = {es_ovf, es_unf, rs_ovf, rs_unf};
    for (int k = 0; k < 8 && busy; k++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tos", tos, 0);
    check("R1 sp", sp, 8'h10);
    check("R1 rp", rp, 8'h80);
    check("R1 busy/flags", {busy, es_ovf, es_unf, rs_ovf, rs_unf}, 0);
    check("R1 rs_dout", rs_dout, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(int'(VEC[i][22:20]), {8'h0, VEC[i][19:16]});
      check("R2/R3/R4 tos", tos, VEC[i][15:12]);
      check("R3/R4 nos", nos, VEC[i][11:8]);
      check("R2/R3 sp", sp, VEC[i][7:0]);
    end

    // R6 / R8: return push, busy timing, data push ignored while busy
    @(negedge clk);
    rs_push = 1; rs_din = 12'hABC;
    @(negedge clk);
    rs_push = 0;
    check("R6 busy 1st", busy, 1);
    es_push = 1; es_din = 4'hF;
    @(negedge clk);
    check("R6 busy 2nd", busy, 1);
    es_push = 0;
    @(negedge clk);
    check("R6 busy end", busy, 0);
    check("R6 rp", rp, 8'h83);
    check("R8 sp held", sp, 8'h12);
    check("R8 tos held", tos, 4'hA);

    run_op(6, 0);
    check("R10 xchg tos", tos, 4'hC);
    run_op(5, 0);
    check("R7 pop entry", rs_dout, 12'hABA);
    check("R7 rp", rp, 8'h80);

    run_op(6, 0);
    check("R11 xchg empty flag", fl, 4'b0001);
    check("R11 xchg empty tos", tos, 4'hC);
    run_op(5, 0);
    check("R11 pop empty flag", fl, 4'b0001);
    check("R11 pop empty dout", rs_dout, 12'hABA);
    check("R11 pop empty rp", rp, 8'h80);

    run_op(4, 12'h111);
    run_op(4, 12'h222);
    check("R6 rp two entries", rp, 8'h86);
    run_op(4, 12'h333);
    check("R11 ovf flag", fl, 4'b0010);
    check("R11 ovf rp", rp, 8'h86);
    run_op(5, 0);
    check("R7 pop 222", rs_dout, 12'h222);
    run_op(5, 0);
    check("R7 pop 111", rs_dout, 12'h111);

    // R9 priority
    @(negedge clk);
    es_push = 1; es_pop = 1; rs_push = 1; es_din = 4'h1; rs_din = 12'h555;
    @(negedge clk);
    {es_push, es_pop, rs_push} = '0;
    check("R9 push wins tos", tos, 4'h1);
    check("R9 push wins sp", sp, 8'h13);
    check("R9 rs untouched", {busy, rp}, {1'b0, 8'h80});

    run_op(1, 12'h2);
    check("R2 sp at ceiling", sp, 8'h14);
    run_op(1, 12'h7);
    check("R5 ovf flag", fl, 4'b1000);
    check("R5 ovf tos", tos, 4'h2);
    check("R5 ovf sp", sp, 8'h14);
    @(negedge clk);
    check("R5 flag one cycle", es_ovf, 0);

    for (int i = 0; i < 8 && sp != es_base; i++) run_op(2, 0);
    check("R3 drained tos", tos, 4'h0);
    run_op(2, 0);
    check("R5 unf flag", fl, 4'b0100);
    check("R5 unf sp", sp, 8'h10);
    run_op(3, 0);
    check("R5 swap unf flag", fl, 4'b0100);
    check("R5 swap unf tos", tos, 4'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule